// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a minimal serial port that keeps no queues. A host issues single-cycle requests of one, two or four bytes at fixed register offsets. Behind them sit a data port, a read-only status word, plain storage for control, divisor, line and level-select settings, and a small interrupt group: a raw event word, an enable mask, the masked view, and a write-one-to-clear port. Writing the data port hands a byte to a transmit sink. Reading it takes the one byte that a receive source offers.

Register offsets: data 0x00, status 0x04, control 0x08 (16 bits), integer divisor 0x0C (16 bits), fractional divisor 0x10 (6 bits), line settings 0x14 (8 bits), level select 0x18 (6 bits), interrupt enable 0x1C, raw events 0x20 (read-only), masked events 0x24 (read-only), event clear 0x28 (write-only, reads zero). Interrupt bit 0 is receive, bit 1 is transmit and bit 2 is receive-timeout. Size code `req_size` is 0 for a byte, 1 for a halfword and 2 for a word. Code 3 is illegal.

A single level interrupt line rises a programmable number of cycles after the masked events first become nonzero. It falls in the same cycle that they return to zero. Read data, the error strobe, the transmit strobe and the end-of-transmission pulse all appear in the cycle after the request.

Top module: `uart_csr_front`

## Requirements
- R1: After reset, control reads 0x300 and level select reads 0x12. Both divisors, line settings, the enable mask, raw events and masked events read 0, and `irq` is low.
- R2: A write stores the low bytes of `req_wdata` selected by the size: 1, 2 or 4 bytes, with the rest taken as zero. Each register keeps only its own width. A read returns the register value truncated to the access size.
- R3: The masked-event register reads as the raw events ANDed with the enable mask.
- R4: A write to the clear port clears every raw event bit that is 1 in the written value. Other bits are left alone.
- R5: A write to the data port puts the low 8 bits on `tx_byte` with `tx_valid` high in the next cycle. The transmit raw bit (bit 1) is set afterwards.
- R6: A read of the data port returns 0 and leaves `rx_take` low when `rx_avail` is low. When `rx_avail` is high, the read returns `rx_byte`, pulses `rx_take` during the request cycle, and clears raw bits 0 and 2.
- R7: A rising edge of `rx_avail` sets raw bits 0 and 2.
- R8: The status word always has bit 0 (clear-to-send) and bit 3 (transmit empty) set. Bit 1 (receive empty) equals NOT `rx_avail` and bit 2 (receive full) equals `rx_avail`.
- R9: `irq` rises exactly IRQ_DELAY cycles after the masked events first become nonzero. It falls in the first cycle they are zero. A drop to zero before the delay expires cancels the count, and the next zero-to-nonzero change starts a full new count.
- R10: A data-port write whose low byte is 0x04 pulses `eot_pulse` alongside `tx_valid` when `eot_en` is high. Otherwise `eot_pulse` stays low.
- R11: A request to an offset outside the map, or with size code 3, raises `acc_err` for one cycle. On a read it returns 0; on a write nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response present |
| rd_data | output | 32 | Read response data |
| acc_err | output | 1 | Illegal access strobe |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Byte to transmit |
| rx_avail | input | 1 | Receive source holds a byte |
| rx_byte | input | 8 | Byte offered by the receive source |
| rx_take | output | 1 | Receive byte consumed this cycle |
| eot_en | input | 1 | Enables end-of-transmission detection |
| eot_pulse | output | 1 | End-of-transmission byte written |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts cycles across the interrupt delay. A design that is one register off would raise `irq` a cycle early or late. The bench also cancels a pending count and checks that the next rise waits the full delay, which a counter that is not reset would cut short. Narrow and truncated accesses are checked against stored values, so a design that dropped the size mask would leak upper bytes. The bench consumes a received byte and checks that raw bits 0 and 2 both fall. It also checks that an illegal-size write leaves a register untouched, which a decoder ignoring the size code would overwrite.

// File: rtl/uart_csr_front.sv
module uart_csr_front #(
  parameter int ADDR_W    = 12,
  parameter int IRQ_DELAY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              acc_err,
  output logic              tx_valid,
  output logic [7:0]        tx_byte,
  input  logic              rx_avail,
  input  logic [7:0]        rx_byte,
  output logic              rx_take,
  input  logic              eot_en,
  output logic              eot_pulse,
  output logic              irq
);
  localparam int INT_W = 3;
  localparam int DLY_W = $clog2(IRQ_DELAY + 1);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] A_IDIV = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] A_FDIV = ADDR_W'(12'h010);
  localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(12'h014);
  localparam logic [ADDR_W-1:0] A_LVL  = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(12'h01C);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_MSKD = ADDR_W'(12'h024);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(12'h028);
  localparam logic [INT_W-1:0] EV_RX = 3'b001;
  localparam logic [INT_W-1:0] EV_TX = 3'b010;
  localparam logic [INT_W-1:0] EV_RT = 3'b100;

  logic [15:0]      ctrl_q, idiv_q;
  logic [5:0]       fdiv_q, lvl_q;
  logic [7:0]       line_q;
  logic [INT_W-1:0] mask_q, raw_q;
  logic             rx_q, irq_q;
  logic [DLY_W-1:0] cnt_q;

  logic [31:0] szmask, wd, rval;
  logic        known, ok, wr, rd;
  logic [INT_W-1:0] ev_set, ev_clr, masked;

  assign szmask = (req_size == 2'd0) ? 32'h0000_00FF :
                  (req_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign wd     = req_wdata & szmask;
  assign ok     = req_valid && known && (req_size != 2'd3);
  assign wr     = ok && req_write;
  assign rd     = ok && !req_write;
  assign rx_take = rd && (req_addr == A_DATA) && rx_avail;
  assign masked = raw_q & mask_q;

  always_comb begin
    known = 1'b1;
    rval  = '0;
    case (req_addr)
      A_DATA: rval = rx_avail ? {24'd0, rx_byte} : 32'd0;
      A_STAT: rval = {28'd0, 1'b1, rx_avail, !rx_avail, 1'b1};
      A_CTRL: rval = {16'd0, ctrl_q};
      A_IDIV: rval = {16'd0, idiv_q};
      A_FDIV: rval = {26'd0, fdiv_q};
      A_LINE: rval = {24'd0, line_q};
      A_LVL:  rval = {26'd0, lvl_q};
      A_MASK: rval = {{(32-INT_W){1'b0}}, mask_q};
      A_RAW:  rval = {{(32-INT_W){1'b0}}, raw_q};
      A_MSKD: rval = {{(32-INT_W){1'b0}}, masked};
      A_CLR:  rval = '0;
      default: known = 1'b0;
    endcase
  end

  assign ev_set = ((wr && req_addr == A_DATA) ? EV_TX : '0) |
                  ((rx_avail && !rx_q) ? (EV_RX | EV_RT) : '0);
  assign ev_clr = ((wr && req_addr == A_CLR) ? wd[INT_W-1:0] : '0) |
                  (rx_take ? (EV_RX | EV_RT) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= 16'h0300;
      idiv_q <= '0;
      fdiv_q <= '0;
      line_q <= '0;
      lvl_q  <= 6'h12;
      mask_q <= '0;
      raw_q  <= '0;
      rx_q   <= 1'b0;
    end else begin
      rx_q  <= rx_avail;
      raw_q <= (raw_q | ev_set) & ~ev_clr;
      if (wr) begin
        case (req_addr)
          A_CTRL: ctrl_q <= wd[15:0];
          A_IDIV: idiv_q <= wd[15:0];
          A_FDIV: fdiv_q <= wd[5:0];
          A_LINE: line_q <= wd[7:0];
          A_LVL:  lvl_q  <= wd[5:0];
          A_MASK: mask_q <= wd[INT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      acc_err   <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
      eot_pulse <= 1'b0;
    end else begin
      rd_valid  <= req_valid && !req_write;
      rd_data   <= rd ? (rval & szmask) : 32'd0;
      acc_err   <= req_valid && !ok;
      tx_valid  <= wr && (req_addr == A_DATA);
      tx_byte   <= wd[7:0];
      eot_pulse <= wr && (req_addr == A_DATA) && eot_en && (wd[7:0] == 8'h04);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || masked == '0) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else if (!irq_q) begin
      if (cnt_q == DLY_W'(IRQ_DELAY - 1)) irq_q <= 1'b1;
      else                                cnt_q <= cnt_q + 1'b1;
    end
  end

  assign irq = irq_q && (masked != '0);
endmodule

// File: rtl/uart_csr_front_chk.sv
module uart_csr_front_chk #(
  parameter int ADDR_W    = 12,
  parameter int IRQ_DELAY = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rx_avail,
  input logic              rx_take,
  input logic              tx_valid,
  input logic [7:0]        tx_byte,
  input logic              eot_pulse,
  input logic              irq,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic              acc_err,
  input logic [2:0]        raw_q,
  input logic [2:0]        mask_q
);
  localparam int ST_W = $clog2(IRQ_DELAY + 2);
  logic [ST_W-1:0] streak;

  always_ff @(posedge clk) begin
    if (!rst_n || (raw_q & mask_q) == 3'b000) streak <= '0;
    else if (streak != ST_W'(IRQ_DELAY)) streak <= streak + 1'b1;
  end

  p_irq_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> streak >= ST_W'(IRQ_DELAY));
  p_irq_needs_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q & mask_q) != 3'b000);
  p_take_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_take |-> rx_avail && req_valid && !req_write);
  p_tx_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(req_valid && req_write && req_addr == '0));
  p_tx_raises_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> raw_q[1]);
  p_eot_with_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eot_pulse |-> tx_valid && tx_byte == 8'h04);
  p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_err && rd_valid) |-> rd_data == 32'd0);
endmodule

bind uart_csr_front uart_csr_front_chk #(.ADDR_W(ADDR_W), .IRQ_DELAY(IRQ_DELAY)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rx_avail(rx_avail), .rx_take(rx_take),
  .tx_valid(tx_valid), .tx_byte(tx_byte), .eot_pulse(eot_pulse), .irq(irq),
  .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
  .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/uart_csr_front_tb_top.sv
module uart_csr_front_tb_top;
  localparam int DLY = 4;
  localparam logic [11:0] A_DATA = 12'h000, A_STAT = 12'h004, A_CTRL = 12'h008,
    A_IDIV = 12'h00C, A_FDIV = 12'h010, A_LINE = 12'h014, A_LVL = 12'h018,
    A_MASK = 12'h01C, A_RAW = 12'h020, A_MSKD = 12'h024, A_CLR = 12'h028;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, acc_err, tx_valid, rx_take, eot_pulse, irq;
  logic [31:0] rd_data;
  logic [7:0]  tx_byte;
  logic rx_avail = 1'b0, eot_en = 1'b0;
  logic [7:0] rx_byte = '0;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] rd_exp_q[$];
  string       rd_tag_q[$];
  logic [7:0]  tx_exp_q[$];
  logic        took;

  always #4 clk = ~clk;

  uart_csr_front #(.ADDR_W(12), .IRQ_DELAY(DLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .rx_avail(rx_avail),
    .rx_byte(rx_byte), .rx_take(rx_take), .eot_en(eot_en),
    .eot_pulse(eot_pulse), .irq(irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [1:0] s, logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
    if (a == A_DATA && s != 2'd3) tx_exp_q.push_back(d[7:0]);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [1:0] s, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
    rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
    #1 took = rx_take;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (rd_exp_q.size() == 0) check("unexpected read response", 1, 0);
      else check(rd_tag_q.pop_front(), rd_data, rd_exp_q.pop_front());
    end
    if (tx_valid) begin
      if (tx_exp_q.size() == 0) check("R5 unexpected tx", 1, 0);
      else check("R5 tx byte", {24'd0, tx_byte}, {24'd0, tx_exp_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 irq after reset", irq, 0);
    check("R1 tx_valid after reset", tx_valid, 0);
    rd(A_CTRL, 2, 32'h300, "R1 control reset");
    rd(A_LVL,  2, 32'h12,  "R1 level reset");
    rd(A_IDIV, 2, 0, "R1 idiv reset");
    rd(A_FDIV, 2, 0, "R1 fdiv reset");
    rd(A_LINE, 2, 0, "R1 line reset");
    rd(A_MASK, 2, 0, "R1 mask reset");
    rd(A_RAW,  2, 0, "R1 raw reset");
    rd(A_MSKD, 2, 0, "R1 masked reset");

    wr(A_IDIV, 2, 32'h1234_ABCD);
    rd(A_IDIV, 2, 32'hABCD, "R2 idiv word");
    wr(A_IDIV, 0, 32'h0000_5A77);
    rd(A_IDIV, 2, 32'h77, "R2 idiv byte write");
    wr(A_CTRL, 1, 32'h1234_5678);
    rd(A_CTRL, 0, 32'h78, "R2 ctrl byte read");
    rd(A_CTRL, 1, 32'h5678, "R2 ctrl half read");
    wr(A_LINE, 2, 32'hFFFF_FFA5);
    rd(A_LINE, 2, 32'hA5, "R2 line width");
    wr(A_FDIV, 2, 32'hFF);
    rd(A_FDIV, 2, 32'h3F, "R2 fdiv width");

    rd(A_STAT, 2, 32'hB, "R8 status no byte");
    rd(A_DATA, 2, 0, "R6 empty data read");
    check("R6 no take when empty", took, 0);

    wr(A_DATA, 2, 32'h0000_0141);
    check("R10 no eot for other byte", eot_pulse, 0);
    rd(A_RAW, 2, 32'h2, "R5 tx bit raised");
    wr(A_DATA, 0, 32'h04);
    check("R10 eot disabled", eot_pulse, 0);
    eot_en = 1'b1;
    wr(A_DATA, 2, 32'h0000_0104);
    check("R10 eot pulse", eot_pulse, 1);
    wr(A_DATA, 2, 32'h05);
    check("R10 eot off for 0x05", eot_pulse, 0);
    eot_en = 1'b0;

    wr(A_CLR, 2, 32'h5);
    rd(A_RAW, 2, 32'h2, "R4 clear leaves other bits");
    wr(A_CLR, 2, 32'h2);
    rd(A_RAW, 2, 32'h0, "R4 clear tx bit");

    @(negedge clk); rx_byte = 8'h3C; rx_avail = 1'b1;
    rd(A_RAW, 2, 32'h5, "R7 rx edge sets rx and rt");
    rd(A_STAT, 2, 32'hD, "R8 status byte pending");
    rd(A_DATA, 0, 32'h3C, "R6 data read returns byte");
    check("R6 take pulsed", took, 1);
    rx_avail = 1'b0;
    rd(A_RAW, 2, 32'h0, "R6 read clears rx and rt");

    wr(A_MASK, 2, 32'h1);
    wr(A_DATA, 2, 32'h55);
    rd(A_MSKD, 2, 32'h0, "R3 masked hides tx");
    check("R9 no irq when masked off", irq, 0);
    wr(A_MASK, 2, 32'h3);
    rd(A_MSKD, 2, 32'h2, "R3 masked shows tx");
    wr(A_MASK, 2, 32'h0);
    check("R9 mask drop deasserts", irq, 0);
    wr(A_CLR, 2, 32'h7);
    wr(A_MASK, 2, 32'h2);

    wr(A_DATA, 2, 32'h61);
    for (int k = 0; k <= DLY + 1; k++) begin
      check($sformatf("R9 irq delay k=%0d", k), irq, (k >= DLY) ? 1 : 0);
      @(negedge clk);
    end
    wr(A_CLR, 2, 32'h2);
    check("R9 immediate deassert", irq, 0);

    wr(A_DATA, 2, 32'h62);
    @(negedge clk);
    wr(A_CLR, 2, 32'h2);
    wr(A_DATA, 2, 32'h63);
    for (int k = 0; k <= DLY; k++) begin
      check($sformatf("R9 restart after cancel k=%0d", k), irq, (k >= DLY) ? 1 : 0);
      @(negedge clk);
    end
    wr(A_CLR, 2, 32'h7);

    rd(12'h0FC, 2, 0, "R11 undefined read zero");
    check("R11 err on undefined read", acc_err, 1);
    wr(A_IDIV, 3, 32'hFFFF);
    check("R11 err on bad size", acc_err, 1);
    rd(A_IDIV, 2, 32'h77, "R11 bad size write ignored");
    check("R11 err is one cycle", acc_err, 0);
    wr(12'h002, 2, 32'hFFFF);
    check("R11 err on misaligned", acc_err, 1);

    repeat (3) @(negedge clk);
    check("queues drained", rd_exp_q.size() + tx_exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule